// File: doc/BRIEF.md
# JTAG Debug Transport

This block sits behind a JTAG test port and turns serial scans into word-wide accesses on a debug module interface. A 16-state TAP controller runs on TCK and is reset asynchronously by an active-low TRST. A 5-bit instruction register selects one of four data registers:

- a 32-bit identification word;
- a 32-bit transport control/status word;
- a 41-bit access register that carries an address, a data word and an operation code to the debug module;
- a 1-bit bypass stage.

A completed access scan with a read or write operation raises a request on a valid/ready request channel. The block then waits on a valid/ready response channel and keeps the returned data and status. The next access scan captures that data and status for shifting out.

Two conditions make an error status sticky. One is a scan that starts while an access is still in flight, which reports busy. The other is a failed response. While the status is sticky, no further requests leave the block. Software clears it by writing a one to bit 16 of the control/status word.

TAP states are Test-Logic-Reset, Run-Test/Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR, linked by the standard TMS transitions. The request link has three states:

- LINK_IDLE moves to LINK_REQ on an accepted update.
- LINK_REQ moves to LINK_RSP on request ready.
- LINK_RSP moves back to LINK_IDLE on response valid.

Top module: `jtag_dbg_transport`

## Requirements
- R1: While TRST is low and after it is released, the controller is in Test-Logic-Reset, the instruction is the identification opcode 0x01, no request or response-ready is raised, and TDO is 0.
- R2: The controller follows the standard 16-state TMS graph, including the Pause and Exit2 detours. Five TCK cycles with TMS high from any state reach Test-Logic-Reset, which restores instruction 0x01.
- R3: Instruction bits shift in LSB first during Shift-IR and take effect at Update-IR. Capture-IR loads 0b00001, and TDO is 0 outside Shift-DR and Shift-IR.
- R4: With instruction 0x01, a data scan returns the 32-bit identification parameter LSB first.
- R5: With instruction 0x10, a data scan returns a word with the version 1 in bits [3:0], the address width (7) in bits [9:4], the sticky status in bits [11:10], and zero elsewhere.
- R6: With instruction 0x11, the 41-bit register holds op in bits [1:0], data in [33:2] and address in [40:34]. At Update-DR, op 1 (read) or 2 (write) issues exactly one request carrying those fields, and op 0 or 3 issues none.
- R7: A request stays valid with stable fields until ready is seen. Response-ready is high only while a response is awaited, and never together with request-valid.
- R8: Capture-DR on the access register loads the status into op (0 success, 2 failed, 3 busy), the last response data into data, and the last issued address into address.
- R9: A capture of the access register while an access is in flight reports busy (3) in that capture and makes busy sticky. While the status is sticky, updates issue no request.
- R10: A response with status 2 (failed) makes that status sticky.
- R11: An update of the control/status word with bit 16 set clears the sticky status. The same update with bit 16 clear leaves it unchanged.
- R12: Any other instruction selects a 1-bit bypass that captures 0, so TDO repeats TDI one bit later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| dmi_req_valid | output | 1 | Request valid |
| dmi_req_ready | input | 1 | Request accepted by debug module |
| dmi_req_addr | output | 7 | Request address |
| dmi_req_data | output | 32 | Request write data |
| dmi_req_op | output | 2 | Request operation (1 read, 2 write) |
| dmi_rsp_valid | input | 1 | Response valid |
| dmi_rsp_ready | output | 1 | Response accepted |
| dmi_rsp_data | input | 32 | Response read data |
| dmi_rsp_status | input | 2 | Response status (0 ok, 2 failed, 3 busy) |

## Verification
The bench first drives a scan into the access register while a slow response is still pending. A design that sampled the old status in that capture would report success for a busy collision. It would also keep issuing requests behind the sticky error, and the bench's request queue flags any such unexpected request.

The bench then writes the control/status word with every bit except 16 set, and after that with only bit 16 set. A design that cleared on any write, or ignored the clear bit, shows the wrong bits [11:10]. A failed response must stick in the same way.

Scans broken by Pause states, and a five-cycle TMS-high escape from Shift-DR, expose a controller whose edges are wrong or that keeps a stale instruction. A bypass scan catches a register of the wrong length.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int IR_W    = 5;
    localparam int DATA_W  = 32;

    localparam logic [IR_W-1:0] IR_IDENT   = 5'h01;
    localparam logic [IR_W-1:0] IR_CTRL    = 5'h10;
    localparam logic [IR_W-1:0] IR_ACCESS  = 5'h11;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

    localparam int CLR_BIT = 16;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSV   = 2'd3
    } acc_op_e;

    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_FAIL = 2'd2;
    localparam logic [1:0] ST_BUSY = 2'd3;

    typedef enum logic [1:0] {
        LINK_IDLE,
        LINK_REQ,
        LINK_RSP
    } link_state_e;

endpackage

// File: rtl/dtm_tap_fsm.sv
module dtm_tap_fsm
    import dtm_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TAP_RESET;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
        endcase
    end

endmodule

// File: rtl/dtm_instr_reg.sv
module dtm_instr_reg
    import dtm_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] instr,
    output logic            sh_out
);

    logic [IR_W-1:0] sh;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            instr <= IR_IDENT;
            sh    <= '0;
        end else begin
            case (state)
                TAP_RESET:  instr <= IR_IDENT;
                TAP_CAP_IR: sh    <= IR_CAPTURE;
                TAP_SH_IR:  sh    <= {tdi, sh[IR_W-1:1]};
                TAP_UPD_IR: instr <= sh;
                default: ;
            endcase
        end
    end

    assign sh_out = sh[0];

endmodule

// File: rtl/dtm_link.sv
module dtm_link
    import dtm_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             upd_go,
    input  logic [ABITS-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [1:0]       upd_op,
    input  logic             cap_acc,
    input  logic             clr,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ABITS-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]       req_op,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [1:0]       rsp_status,
    output logic [1:0]       sticky,
    output logic             in_flight,
    output logic [DATA_W-1:0] rd_data
);

    link_state_e lstate;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            lstate   <= LINK_IDLE;
            sticky   <= ST_OK;
            rd_data  <= '0;
            req_addr <= '0;
            req_data <= '0;
            req_op   <= OP_NOP;
        end else begin
            if (clr) sticky <= ST_OK;
            unique case (lstate)
                LINK_IDLE: begin
                    if (upd_go && sticky == ST_OK) begin
                        req_addr <= upd_addr;
                        req_data <= upd_data;
                        req_op   <= upd_op;
                        lstate   <= LINK_REQ;
                    end
                end
                LINK_REQ: begin
                    if (req_ready) lstate <= LINK_RSP;
                end
                LINK_RSP: begin
                    if (rsp_valid) begin
                        rd_data <= rsp_data;
                        if (rsp_status != ST_OK && sticky == ST_OK) sticky <= rsp_status;
                        lstate <= LINK_IDLE;
                    end
                end
                default: lstate <= LINK_IDLE;
            endcase
            if (cap_acc && lstate != LINK_IDLE) sticky <= ST_BUSY;
        end
    end

    always_comb begin
        req_valid = (lstate == LINK_REQ);
        rsp_ready = (lstate == LINK_RSP);
        in_flight = (lstate != LINK_IDLE);
    end

endmodule

// File: rtl/jtag_dbg_transport.sv
module jtag_dbg_transport
    import dtm_pkg::*;
#(
    parameter int          ABITS      = 7,
    parameter logic [31:0] IDENT_WORD = 32'h1BEE_F00D
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              dmi_req_valid,
    input  logic              dmi_req_ready,
    output logic [ABITS-1:0]  dmi_req_addr,
    output logic [31:0]       dmi_req_data,
    output logic [1:0]        dmi_req_op,
    input  logic              dmi_rsp_valid,
    output logic              dmi_rsp_ready,
    input  logic [31:0]       dmi_rsp_data,
    input  logic [1:0]        dmi_rsp_status
);

    localparam int DRW = ABITS + DATA_W + 2;

    tap_state_e       tap_state;
    logic [IR_W-1:0]  ir_q;
    logic             ir_tdo;
    logic [DRW-1:0]   dr_sh;
    logic [DRW-1:0]   dr_nxt;
    logic [DRW-1:0]   cap_val;
    logic [DRW:0]     dr_ext;
    logic [1:0]       dmi_sticky;
    logic             link_busy;
    logic [DATA_W-1:0] link_rdata;
    logic [DATA_W-1:0] ctrl_word;
    logic             sel_id, sel_ctrl, sel_acc;
    int               dr_len;
    logic             upd_go, cap_acc, clr;

    dtm_tap_fsm u_tap (
        .tck   (tck),
        .trst_n(trst_n),
        .tms   (tms),
        .state (tap_state)
    );

    dtm_instr_reg u_ir (
        .tck   (tck),
        .trst_n(trst_n),
        .state (tap_state),
        .tdi   (tdi),
        .instr (ir_q),
        .sh_out(ir_tdo)
    );

    assign sel_id   = (ir_q == IR_IDENT);
    assign sel_ctrl = (ir_q == IR_CTRL);
    assign sel_acc  = (ir_q == IR_ACCESS);

    assign ctrl_word = {{(DATA_W-12){1'b0}}, dmi_sticky, 6'(ABITS), 4'd1};

    always_comb begin
        cap_val = '0;
        if (sel_id)        cap_val[DATA_W-1:0] = IDENT_WORD;
        else if (sel_ctrl) cap_val[DATA_W-1:0] = ctrl_word;
        else if (sel_acc)  cap_val = {dmi_req_addr, link_rdata, (link_busy ? ST_BUSY : dmi_sticky)};
    end

    always_comb begin
        if (sel_id || sel_ctrl) dr_len = DATA_W;
        else if (sel_acc)       dr_len = DRW;
        else                    dr_len = 1;
    end

    assign dr_ext = {1'b0, dr_sh};

    always_comb begin
        for (int i = 0; i < DRW; i++) begin
            if (i == dr_len - 1)     dr_nxt[i] = tdi;
            else if (i < dr_len - 1) dr_nxt[i] = dr_ext[i+1];
            else                     dr_nxt[i] = 1'b0;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            dr_sh <= '0;
        end else begin
            case (tap_state)
                TAP_CAP_DR: dr_sh <= cap_val;
                TAP_SH_DR:  dr_sh <= dr_nxt;
                default: ;
            endcase
        end
    end

    assign upd_go  = (tap_state == TAP_UPD_DR) && sel_acc &&
                     (dr_sh[1:0] == OP_READ || dr_sh[1:0] == OP_WRITE);
    assign cap_acc = (tap_state == TAP_CAP_DR) && sel_acc;
    assign clr     = (tap_state == TAP_UPD_DR) && sel_ctrl && dr_sh[CLR_BIT];

    dtm_link #(.ABITS(ABITS)) u_link (
        .tck       (tck),
        .trst_n    (trst_n),
        .upd_go    (upd_go),
        .upd_addr  (dr_sh[DRW-1:DATA_W+2]),
        .upd_data  (dr_sh[DATA_W+1:2]),
        .upd_op    (dr_sh[1:0]),
        .cap_acc   (cap_acc),
        .clr       (clr),
        .req_valid (dmi_req_valid),
        .req_ready (dmi_req_ready),
        .req_addr  (dmi_req_addr),
        .req_data  (dmi_req_data),
        .req_op    (dmi_req_op),
        .rsp_valid (dmi_rsp_valid),
        .rsp_ready (dmi_rsp_ready),
        .rsp_data  (dmi_rsp_data),
        .rsp_status(dmi_rsp_status),
        .sticky    (dmi_sticky),
        .in_flight (link_busy),
        .rd_data   (link_rdata)
    );

    always_comb begin
        unique case (tap_state)
            TAP_SH_DR: tdo = dr_sh[0];
            TAP_SH_IR: tdo = ir_tdo;
            default:   tdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
    import dtm_pkg::*;
#(
    parameter int ABITS = 7
) (
    input logic             tck,
    input logic             trst_n,
    input tap_state_e       state,
    input logic [IR_W-1:0]  ir,
    input logic             tdo,
    input logic             req_valid,
    input logic             req_ready,
    input logic [ABITS-1:0] req_addr,
    input logic [31:0]      req_data,
    input logic             rsp_ready,
    input logic [1:0]       sticky
);

    p_tlr_ident_r2: assert property (@(posedge tck) disable iff (!trst_n)
        state == TAP_RESET |=> ir == IR_IDENT);

    p_tdo_quiet_r3: assert property (@(posedge tck) disable iff (!trst_n)
        !(state inside {TAP_SH_DR, TAP_SH_IR}) |-> !tdo);

    p_req_hold_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

    p_chan_excl_r7: assert property (@(posedge tck) disable iff (!trst_n)
        !(req_valid && rsp_ready));

    p_busy_capture_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TAP_CAP_DR && ir == IR_ACCESS && (req_valid || rsp_ready)) |=> sticky == ST_BUSY);

    p_sticky_blocks_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (sticky != ST_OK && !req_valid) |=> !req_valid);

endmodule

bind jtag_dbg_transport dtm_checker #(.ABITS(ABITS)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (tap_state),
    .ir       (ir_q),
    .tdo      (tdo),
    .req_valid(dmi_req_valid),
    .req_ready(dmi_req_ready),
    .req_addr (dmi_req_addr),
    .req_data (dmi_req_data),
    .rsp_ready(dmi_rsp_ready),
    .sticky   (dmi_sticky)
);

// File: tb/jtag_dbg_transport_tb_top.sv
`timescale 1ns/1ps
module jtag_dbg_transport_tb_top;

    localparam logic [31:0] IDW = 32'h1BEE_F00D;

    logic        tck = 1'b0;
    logic        trst_n, tms, tdi, tdo;
    logic        dmi_req_valid, dmi_req_ready;
    logic [6:0]  dmi_req_addr;
    logic [31:0] dmi_req_data;
    logic [1:0]  dmi_req_op;
    logic        dmi_rsp_valid, dmi_rsp_ready;
    logic [31:0] dmi_rsp_data;
    logic [1:0]  dmi_rsp_status;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 tck = ~tck;

    jtag_dbg_transport dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .dmi_req_valid(dmi_req_valid), .dmi_req_ready(dmi_req_ready),
        .dmi_req_addr(dmi_req_addr), .dmi_req_data(dmi_req_data), .dmi_req_op(dmi_req_op),
        .dmi_rsp_valid(dmi_rsp_valid), .dmi_rsp_ready(dmi_rsp_ready),
        .dmi_rsp_data(dmi_rsp_data), .dmi_rsp_status(dmi_rsp_status)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- debug module model ----------------
    logic [31:0] regs [128];
    logic [40:0] exp_q [$];
    int          rsp_lat = 3;
    int          rdy_dly = 1;
    int          lat_cnt, rdy_cnt;
    bit          m_busy = 0;
    logic [6:0]  l_addr;
    logic [31:0] l_data;
    logic [1:0]  l_op;

    always @(negedge tck) begin
        if (!trst_n) begin
            dmi_req_ready  = 1'b0;
            dmi_rsp_valid  = 1'b0;
            dmi_rsp_data   = '0;
            dmi_rsp_status = '0;
            m_busy  = 0;
            rdy_cnt = 0;
        end else if (dmi_rsp_valid) begin
            dmi_rsp_valid = 1'b0;
            m_busy = 0;
        end else if (dmi_req_ready) begin
            dmi_req_ready = 1'b0;
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected request", {l_addr, l_data, l_op}, 0);
            end else begin
                logic [40:0] e;
                e = exp_q.pop_front();
                chk(e == {l_addr, l_data, l_op}, "R6 request fields", {l_addr, l_data, l_op}, e);
            end
            dmi_rsp_status = 2'd0;
            dmi_rsp_data   = '0;
            if (l_addr == 7'h7F) dmi_rsp_status = 2'd2;
            else if (l_op == 2'd2) regs[l_addr] = l_data;
            else dmi_rsp_data = regs[l_addr];
            m_busy  = 1;
            lat_cnt = rsp_lat;
        end else if (m_busy) begin
            chk(dmi_rsp_ready && !dmi_req_valid, "R7 awaiting response", {dmi_rsp_ready, dmi_req_valid}, 2'b10);
            if (lat_cnt == 0) dmi_rsp_valid = 1'b1;
            else lat_cnt--;
        end else if (dmi_req_valid) begin
            if (rdy_cnt >= rdy_dly) begin
                dmi_req_ready = 1'b1;
                l_addr = dmi_req_addr;
                l_data = dmi_req_data;
                l_op   = dmi_req_op;
                rdy_cnt = 0;
            end else begin
                rdy_cnt++;
            end
        end else begin
            chk(!dmi_rsp_ready, "R7 no ready when idle", dmi_rsp_ready, 0);
        end
    end

    // ---------------- JTAG driver ----------------
    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck);
    endtask

    task automatic step_rd(input logic m, input logic d, output logic o);
        tms = m; tdi = d; o = tdo;
        @(posedge tck); @(negedge tck);
    endtask

    task automatic idle(input int n);
        repeat (n) step(0, 0);
    endtask

    task automatic scan_ir(input logic [4:0] v, output logic [4:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step_rd(i == 4, v[i], cap[i]);
        step(0, 0); step(1, 0); step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input logic [40:0] din, input int len, input int pause_at, output logic [40:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < len; i++) begin
            step_rd((i == len - 1) || (i == pause_at), din[i], dout[i]);
            if (i == pause_at && i != len - 1) begin
                step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic acc_scan(input logic [1:0] op, input logic [6:0] a, input logic [31:0] d,
                            input bit issue, output logic [40:0] cap);
        if (issue) exp_q.push_back({a, d, op});
        scan_dr({a, d, op}, 41, -1, cap);
    endtask

    function automatic logic [31:0] ctrl_exp(input logic [1:0] st);
        return {20'b0, st, 6'd7, 4'd1};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #1000000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        logic [4:0]  irc;
        logic [40:0] o;
        for (int i = 0; i < 128; i++) regs[i] = 32'h0;
        trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
        repeat (3) @(negedge tck);
        chk(!dmi_req_valid && !dmi_rsp_ready && !tdo, "R1 reset outputs",
            {dmi_req_valid, dmi_rsp_ready, tdo}, 0);
        trst_n = 1'b1;
        step(1, 0);
        step(0, 0);

        // R1 R4: identification without any IR scan
        scan_dr('0, 32, -1, o);
        chk(o[31:0] == IDW, "R4 ident after reset (R1)", o[31:0], IDW);

        // R3: IR capture pattern
        scan_ir(5'h10, irc);
        chk(irc == 5'b00001, "R3 IR capture", irc, 5'b00001);

        // R5: control word
        scan_dr('0, 32, -1, o);
        chk(o[31:0] == ctrl_exp(2'd0), "R5 control word", o[31:0], ctrl_exp(2'd0));

        // R2: paused scan of identification
        scan_ir(5'h01, irc);
        scan_dr('0, 32, 12, o);
        chk(o[31:0] == IDW, "R2 paused ident scan", o[31:0], IDW);

        // R12: bypass
        scan_ir(5'h1F, irc);
        scan_dr(41'hA5, 8, -1, o);
        chk(o[7:0] == 8'h4A, "R12 bypass delay", o[7:0], 8'h4A);

        // R2: five TMS high from Shift-DR returns to reset with ident selected
        step(1, 0); step(0, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        scan_dr('0, 32, -1, o);
        chk(o[31:0] == IDW, "R2 TMS escape restores ident", o[31:0], IDW);

        // R6 R7 R8: write then read round trip
        scan_ir(5'h11, irc);
        acc_scan(2'd2, 7'h05, 32'hCAFE_1234, 1, o);
        chk(o[1:0] == 2'd0, "R8 initial status", o[1:0], 0);
        idle(20);
        rdy_dly = 4;
        acc_scan(2'd1, 7'h05, 32'h0, 1, o);
        idle(20);
        acc_scan(2'd0, 7'h00, 32'h0, 0, o);
        chk(o[1:0] == 2'd0, "R8 status ok", o[1:0], 0);
        chk(o[33:2] == 32'hCAFE_1234, "R8 read data", o[33:2], 32'hCAFE_1234);
        chk(o[40:34] == 7'h05, "R8 last address", o[40:34], 7'h05);
        idle(10);
        chk(!dmi_req_valid && exp_q.size() == 0, "R6 nop issues nothing", exp_q.size(), 0);

        // R6: op 3 issues nothing
        acc_scan(2'd3, 7'h09, 32'h1, 0, o);
        idle(10);
        chk(!dmi_req_valid, "R6 reserved op", dmi_req_valid, 0);

        // R9: busy collision
        rdy_dly = 1; rsp_lat = 60;
        acc_scan(2'd2, 7'h0A, 32'h1111_2222, 1, o);
        acc_scan(2'd0, 7'h00, 32'h0, 0, o);
        chk(o[1:0] == 2'd3, "R9 busy on capture", o[1:0], 3);
        idle(100);
        rsp_lat = 3;
        acc_scan(2'd1, 7'h0A, 32'h0, 0, o);
        chk(o[1:0] == 2'd3, "R9 busy sticks", o[1:0], 3);
        idle(20);
        chk(exp_q.size() == 0 && !dmi_req_valid, "R9 no request while sticky", exp_q.size(), 0);

        // R5 R11: sticky in control word, clear only with bit 16
        scan_ir(5'h10, irc);
        scan_dr({9'b0, 32'hFFFE_FFFF}, 32, -1, o);
        scan_dr('0, 32, -1, o);
        chk(o[31:0] == ctrl_exp(2'd3), "R11 write without clear bit (R5)", o[31:0], ctrl_exp(2'd3));
        scan_dr({9'b0, 32'h0001_0000}, 32, -1, o);
        scan_dr('0, 32, -1, o);
        chk(o[31:0] == ctrl_exp(2'd0), "R11 clear bit", o[31:0], ctrl_exp(2'd0));

        // R10: failed response sticks
        scan_ir(5'h11, irc);
        acc_scan(2'd0, 7'h00, 32'h0, 0, o);
        chk(o[1:0] == 2'd0, "R11 status after clear", o[1:0], 0);
        acc_scan(2'd1, 7'h7F, 32'h0, 1, o);
        idle(20);
        acc_scan(2'd1, 7'h05, 32'h0, 0, o);
        chk(o[1:0] == 2'd2, "R10 failed status", o[1:0], 2);
        idle(20);
        acc_scan(2'd0, 7'h00, 32'h0, 0, o);
        chk(o[1:0] == 2'd2, "R10 failed sticks", o[1:0], 2);
        scan_ir(5'h10, irc);
        scan_dr({9'b0, 32'h0001_0000}, 32, -1, o);
        scan_ir(5'h11, irc);
        acc_scan(2'd1, 7'h05, 32'h0, 1, o);
        idle(20);
        acc_scan(2'd0, 7'h00, 32'h0, 0, o);
        chk(o[1:0] == 2'd0 && o[33:2] == 32'hCAFE_1234, "R11 recovery read",
            {o[33:2], o[1:0]}, {32'hCAFE_1234, 2'd0});

        idle(10);
        chk(exp_q.size() == 0, "R6 all requests seen", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule